// File: doc/BRIEF.md
# I2C Protected Control-Register Target

This block is an I2C target that holds a single 8-bit control register with the write discipline of a nonvolatile cell. It oversamples SCL and SDA with the system clock and recognises start, repeated start and stop. It answers to one fixed 7-bit device address. A write carries a byte address and then exactly one data byte. The write takes effect only when a stop follows that byte's acknowledge. After the commit the block reports a busy period of a fixed number of system clocks, and during that period it ignores the bus.

Two guards protect the register. A write-enable latch must first be set by writing a key value to a reserved byte address. A write-protect pin, while high, makes the target refuse the data byte of a register write. A read uses a dummy write of the byte address, then a repeated start with the read direction. The target then shifts out the register for as long as the controller acknowledges.

The state machine has eleven states:

| State | Role |
|-------|------|
| ST_IDLE | Waits for a start. |
| ST_DEVADR | Receives the address byte. |
| ST_ADR_ACK | Drives the address acknowledge. |
| ST_BYTEADR | Receives the byte address. |
| ST_BA_ACK | Drives its acknowledge. |
| ST_DATA | Receives the data byte. |
| ST_D_ACK | Drives the data acknowledge. |
| ST_WAITSTOP | Holds a pending write. |
| ST_TX | Shifts the register out. |
| ST_TX_ACK | Samples the controller's acknowledge. |
| ST_HOLD | Stays silent until the next start or stop. |

Transitions:

- A start moves any state to ST_DEVADR.
- A stop moves any state to ST_IDLE. The pending write commits only when the stop arrives in ST_WAITSTOP.
- A busy period forces ST_IDLE.
- The other transitions happen on a synchronised SCL falling edge:
  - ST_DEVADR goes to ST_ADR_ACK on a match, or to ST_HOLD otherwise.
  - ST_ADR_ACK goes to ST_TX for a read, or to ST_BYTEADR for a write.
  - ST_BYTEADR goes to ST_BA_ACK.
  - ST_BA_ACK goes to ST_DATA.
  - ST_DATA goes to ST_D_ACK, or to ST_HOLD when write-protect refuses the byte.
  - ST_D_ACK goes to ST_WAITSTOP.
  - ST_WAITSTOP goes to ST_HOLD when a second data byte begins.
  - ST_TX goes to ST_TX_ACK after eight bits.
  - ST_TX_ACK goes back to ST_TX after an acknowledge, or to ST_HOLD after a not-acknowledge.

Top module: `i2c_ctlreg_slave`

## Requirements
- R1: After reset, SDA is released (sda_oe_o = 0), busy_o = 0, ctl_o equals CTL_INIT (default 0x00) and the write-enable latch is clear.
- R2: The first byte after a start is received MSB first. Bits 7:1 are the device address and bit 0 is the direction (1 = read, 0 = write). A write-direction byte is acknowledged only when bits 7:1 equal DEV_ADDR (default 0x2C).
- R3: A write is address byte, byte address 0x00 (CTL_ADDR), one data byte and a stop. With the latch set and WP low, every byte is acknowledged and ctl_o takes the data value when the stop is seen.
- R4: Writing 0xA5 (WEL_KEY) to byte address 0xF0 (WEL_ADDR) sets the write-enable latch, and any other value written there clears it. Neither write changes ctl_o. A register write made while the latch is clear is acknowledged but leaves ctl_o unchanged.
- R5: While wp_i is high, the data byte of a write to CTL_ADDR is not acknowledged and ctl_o keeps its value.
- R6: If a second data byte follows the acknowledged data byte, the write is abandoned, even when a stop comes later.
- R7: A stop that arrives before the data byte and its acknowledge are complete discards the write.
- R8: A committed register write holds busy_o high for exactly WR_CYC system clocks. During that time no address is acknowledged.
- R9: A read is the address byte (write), the byte address, a repeated start, and then the address byte with bit 0 = 1. The target acknowledges and returns ctl_o MSB first. The value is sent again after each controller acknowledge, and SDA is released after a not-acknowledge.
- R10: An address byte with the read direction is not acknowledged unless a byte address was received earlier in the same transfer.
- R11: Asserting rst_n low in the middle of a write discards it: the following stop starts no busy period and the latch is clear again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | When 1, pull SDA low (open drain) |
| wp_i | input | 1 | Write protect for the control register |
| busy_o | output | 1 | Internal write cycle in progress |
| ctl_o | output | 8 | Current control register value |

## Verification
Each bus line passes two synchroniser flops and an edge register. As a result, an acknowledge or register bit appears on SDA three system clocks after the SCL falling edge that calls for it. A commit reaches ctl_o and busy_o three clocks after SDA rises in the stop. The bench changes SDA a quarter bit, eight clocks, after each SCL fall and samples it a quarter bit after each SCL rise. It checks ctl_o and the busy length only after WR_CYC plus a margin of clocks have passed since the stop. The busy period is measured by counting busy_o at every falling clock edge, so its length is checked to the exact cycle.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
    localparam int BYTE_W = 8;
    localparam int BCNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_ADR_ACK,
        ST_BYTEADR,
        ST_BA_ACK,
        ST_DATA,
        ST_D_ACK,
        ST_WAITSTOP,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD
    } st_e;
endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_line
            logic [STAGES-1:0] pipe;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= {pipe[STAGES-2:0], d_i[i]};
            end
            assign q_o[i] = pipe[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/i2cr_busev.sv
module i2cr_busev (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cr_wrtimer.sv
module i2cr_wrtimer #(
    parameter int unsigned CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYC + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (start_i)    cnt <= CW'(CYC);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy_o = (cnt != '0);

    // R8: a new write cycle is never launched while one is running
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
endmodule

// File: rtl/i2c_ctlreg_slave.sv
module i2c_ctlreg_slave
    import i2cr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2C,
    parameter logic [7:0] CTL_ADDR    = 8'h00,
    parameter logic [7:0] WEL_ADDR    = 8'hF0,
    parameter logic [7:0] WEL_KEY     = 8'hA5,
    parameter logic [7:0] CTL_INIT    = 8'h00,
    parameter int unsigned WR_CYC     = 200,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic       wp_i,
    output logic       busy_o,
    output logic [7:0] ctl_o
);
    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_p, stop_p;
    logic busy, commit, nv_start;

    st_e                state, state_n;
    logic [BCNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0]  shreg, txsh, baddr, pend, ctl_q;
    logic               rw_q, armed, mack, wel_q;
    logic               rx_state, byte_done, adr_ok, wp_block;

    i2cr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({scl_i, sda_i}),
        .q_o  ({scl_s, sda_s})
    );

    i2cr_busev u_busev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_p (start_p),
        .stop_p  (stop_p)
    );

    i2cr_wrtimer #(.CYC(WR_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(nv_start),
        .busy_o (busy)
    );

    assign rx_state  = (state == ST_DEVADR) || (state == ST_BYTEADR) || (state == ST_DATA);
    assign byte_done = (bitcnt == BCNT_W'(BYTE_W));
    assign adr_ok    = (shreg[7:1] == DEV_ADDR) && (!shreg[0] || armed);
    assign wp_block  = (baddr == CTL_ADDR) && wp_i;

    // next-state logic
    always_comb begin
        state_n = state;
        if (busy)         state_n = ST_IDLE;
        else if (start_p) state_n = ST_DEVADR;
        else if (stop_p)  state_n = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE, ST_HOLD: state_n = state;
                ST_DEVADR:   if (scl_fall && byte_done) state_n = adr_ok ? ST_ADR_ACK : ST_HOLD;
                ST_ADR_ACK:  if (scl_fall) state_n = rw_q ? ST_TX : ST_BYTEADR;
                ST_BYTEADR:  if (scl_fall && byte_done) state_n = ST_BA_ACK;
                ST_BA_ACK:   if (scl_fall) state_n = ST_DATA;
                ST_DATA:     if (scl_fall && byte_done) state_n = wp_block ? ST_HOLD : ST_D_ACK;
                ST_D_ACK:    if (scl_fall) state_n = ST_WAITSTOP;
                ST_WAITSTOP: if (scl_fall) state_n = ST_HOLD;
                ST_TX:       if (scl_fall && bitcnt == BCNT_W'(BYTE_W - 1)) state_n = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) state_n = mack ? ST_TX : ST_HOLD;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // state register and bit-level datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            txsh   <= '0;
            baddr  <= '0;
            pend   <= '0;
            rw_q   <= 1'b0;
            armed  <= 1'b0;
            mack   <= 1'b0;
        end else begin
            state <= state_n;

            if (state_n != state || (start_p && !busy))
                bitcnt <= '0;
            else if (rx_state && scl_rise && !byte_done)
                bitcnt <= bitcnt + 1'b1;
            else if (state == ST_TX && scl_fall)
                bitcnt <= bitcnt + 1'b1;

            if (rx_state && scl_rise && !byte_done)
                shreg <= {shreg[BYTE_W-2:0], sda_s};

            if (state == ST_DEVADR && state_n == ST_ADR_ACK) rw_q  <= shreg[0];
            if (state == ST_BYTEADR && state_n == ST_BA_ACK) baddr <= shreg;
            if (state == ST_DATA && state_n == ST_D_ACK)     pend  <= shreg;

            if (busy || stop_p)
                armed <= 1'b0;
            else if (state == ST_BA_ACK && state_n == ST_DATA)
                armed <= 1'b1;

            if (state_n == ST_TX && state != ST_TX)
                txsh <= ctl_q;
            else if (state == ST_TX && scl_fall)
                txsh <= {txsh[BYTE_W-2:0], 1'b0};

            if (state == ST_TX_ACK && scl_rise)
                mack <= ~sda_s;
        end
    end

    // commit of a completed write at the stop
    assign commit   = stop_p && !busy && (state == ST_WAITSTOP);
    assign nv_start = commit && (baddr == CTL_ADDR) && wel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_INIT;
            wel_q <= 1'b0;
        end else if (commit) begin
            if (baddr == CTL_ADDR && wel_q) ctl_q <= pend;
            if (baddr == WEL_ADDR)          wel_q <= (pend == WEL_KEY);
        end
    end

    // outputs
    always_comb begin
        sda_oe_o = 1'b0;
        case (state)
            ST_ADR_ACK, ST_BA_ACK, ST_D_ACK: sda_oe_o = 1'b1;
            ST_TX:                           sda_oe_o = ~txsh[BYTE_W-1];
            default:                         sda_oe_o = 1'b0;
        endcase
    end

    assign busy_o = busy;
    assign ctl_o  = ctl_q;

    // R8: nothing is driven onto SDA during the internal write cycle
    a_r8_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe_o);

    // R3: the register changes only on a stop that ends a pending write
    a_r3_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q) |-> $past(stop_p && state == ST_WAITSTOP));

    // R4: the register changes only while the enable latch was set
    a_r4_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q) |-> $past(wel_q));

    // R5: a register data byte is only acknowledged with write protect low
    a_r5_wp_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_D_ACK && $past(state) == ST_DATA && baddr == CTL_ADDR) |-> !$past(wp_i));

    // R9: the register is shifted out only in a read-direction transfer
    a_r9_tx_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX) |-> rw_q);
endmodule

// File: tb/i2c_ctlreg_slave_tb.sv
module i2c_ctlreg_slave_tb;
    localparam int         WR  = 64;
    localparam int         Q   = 8;
    localparam logic [6:0] DEV = 7'h2C;
    localparam logic [7:0] CTL = 8'h00;
    localparam logic [7:0] WEA = 8'hF0;
    localparam logic [7:0] KEY = 8'hA5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       wp    = 1'b0;
    logic       sda_oe, busy;
    logic [7:0] ctl;
    wire        sda_bus = m_sda & ~sda_oe;

    int   nchk = 0;
    int   nerr = 0;
    int   busy_cnt = 0;
    logic busy_clr = 1'b0;

    always @(negedge clk) begin
        if (busy_clr)  busy_cnt <= 0;
        else if (busy) busy_cnt <= busy_cnt + 1;
    end

    i2c_ctlreg_slave #(.DEV_ADDR(DEV), .CTL_ADDR(CTL), .WEL_ADDR(WEA),
                       .WEL_KEY(KEY), .CTL_INIT(8'h00), .WR_CYC(WR)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (m_scl),
        .sda_i   (sda_bus),
        .sda_oe_o(sda_oe),
        .wp_i    (wp),
        .busy_o  (busy),
        .ctl_o   (ctl)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_busy();
        busy_clr = 1'b1;
        wq(1);
        busy_clr = 1'b0;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic wbit(input logic b);
        m_sda = b;    wq(Q);
        m_scl = 1'b1; wq(2 * Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic rbit(output logic b);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        b = sda_bus;  wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(x);
        ack = ~x;
    endtask

    task automatic rbyte(output logic [7:0] v, input logic ack);
        logic x;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            rbit(x);
            v = {v[6:0], x};
        end
        wbit(~ack);
    endtask

    task automatic wr_txn(input logic [7:0] ba, input logic [7:0] d,
                          output logic a_ack, output logic d_ack);
        logic b_ack;
        bus_start();
        wbyte({DEV, 1'b0}, a_ack);
        wbyte(ba, b_ack);
        wbyte(d, d_ack);
        d_ack = d_ack & b_ack;
        bus_stop();
    endtask

    task automatic rd_txn(input logic [7:0] ba, output logic ok,
                          output logic [7:0] b1, output logic [7:0] b2);
        logic a1, a2, a3;
        bus_start();
        wbyte({DEV, 1'b0}, a1);
        wbyte(ba, a2);
        bus_start();
        wbyte({DEV, 1'b1}, a3);
        rbyte(b1, 1'b1);
        rbyte(b2, 1'b0);
        bus_stop();
        ok = a1 & a2 & a3;
    endtask

    task automatic settle();
        wq(WR + 16);
    endtask

    initial begin : main
        logic aa, da, ok, x;
        logic [7:0] b1, b2;
        logic [7:0] vals [5] = '{8'h3C, 8'hFF, 8'h81, 8'h00, 8'h96};

        wq(5);
        rst_n = 1'b1;
        wq(4);
        chk("R1 sda released", int'(sda_oe), 0);
        chk("R1 busy clear", int'(busy), 0);
        chk("R1 ctl reset value", int'(ctl), 0);

        // R2: sweep every device address with the write direction
        for (int a = 0; a < 128; a++) begin
            bus_start();
            wbyte({a[6:0], 1'b0}, aa);
            bus_stop();
            chk("R2 address match", int'(aa), (a[6:0] == DEV) ? 1 : 0);
        end

        // R4 / R1: latch clear after reset, register write ignored
        clr_busy();
        wr_txn(CTL, 8'h5E, aa, da);
        settle();
        chk("R4 ack without latch", int'(aa & da), 1);
        chk("R4 ctl unchanged without latch", int'(ctl), 0);
        chk("R4 no busy without latch", busy_cnt, 0);

        // R4: set the latch
        clr_busy();
        wr_txn(WEA, KEY, aa, da);
        settle();
        chk("R4 latch write acked", int'(aa & da), 1);
        chk("R4 latch write leaves ctl", int'(ctl), 0);
        chk("R4 latch write no busy", busy_cnt, 0);

        // R3 / R8 / R9: write and read back several patterns
        for (int i = 0; i < 5; i++) begin
            clr_busy();
            wr_txn(CTL, vals[i], aa, da);
            if (i == 0) begin
                bus_start();
                wbyte({DEV, 1'b0}, x);
                bus_stop();
                chk("R8 no ack while busy", int'(x), 0);
            end
            settle();
            chk("R3 data acked", int'(aa & da), 1);
            chk("R3 ctl updated", int'(ctl), int'(vals[i]));
            chk("R8 busy length", busy_cnt, WR);
            rd_txn(CTL, ok, b1, b2);
            chk("R9 read acked", int'(ok), 1);
            chk("R9 first read byte", int'(b1), int'(vals[i]));
            chk("R9 repeated read byte", int'(b2), int'(vals[i]));
            chk("R9 sda released after nack", int'(sda_oe), 0);
        end

        // R5: write protect
        wp = 1'b1;
        clr_busy();
        wr_txn(CTL, 8'h42, aa, da);
        settle();
        chk("R5 data not acked", int'(da), 0);
        chk("R5 ctl kept", int'(ctl), 8'h96);
        chk("R5 no busy", busy_cnt, 0);
        wp = 1'b0;

        // R6: second data byte aborts
        clr_busy();
        bus_start();
        wbyte({DEV, 1'b0}, aa);
        wbyte(CTL, x);
        wbyte(8'h24, da);
        wbyte(8'h25, x);
        bus_stop();
        settle();
        chk("R6 first byte acked", int'(da), 1);
        chk("R6 second byte not acked", int'(x), 0);
        chk("R6 ctl kept", int'(ctl), 8'h96);
        chk("R6 no busy", busy_cnt, 0);

        // R7: stop in the middle of the data byte
        clr_busy();
        bus_start();
        wbyte({DEV, 1'b0}, aa);
        wbyte(CTL, x);
        wbit(1'b0); wbit(1'b1); wbit(1'b1); wbit(1'b0);
        bus_stop();
        settle();
        chk("R7 ctl kept", int'(ctl), 8'h96);
        chk("R7 no busy", busy_cnt, 0);

        // R10: read direction without a byte address
        bus_start();
        wbyte({DEV, 1'b1}, x);
        bus_stop();
        chk("R10 bare read not acked", int'(x), 0);

        // R4: clearing the latch
        wr_txn(WEA, 8'h00, aa, da);
        settle();
        clr_busy();
        wr_txn(CTL, 8'h11, aa, da);
        settle();
        chk("R4 cleared latch blocks write", int'(ctl), 8'h96);
        chk("R4 cleared latch no busy", busy_cnt, 0);
        wr_txn(WEA, KEY, aa, da);
        settle();

        // R11: reset in the middle of a write
        clr_busy();
        bus_start();
        wbyte({DEV, 1'b0}, aa);
        wbyte(CTL, x);
        wbyte(8'h77, da);
        rst_n = 1'b0;
        wq(4);
        rst_n = 1'b1;
        wq(2);
        bus_stop();
        settle();
        chk("R11 no busy after reset", busy_cnt, 0);
        chk("R11 ctl at reset value", int'(ctl), 0);
        clr_busy();
        wr_txn(CTL, 8'h12, aa, da);
        settle();
        chk("R11 latch cleared by reset", int'(ctl), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr + 1, nchk + 1);
        $finish;
    end
endmodule